// File: doc/BRIEF.md
# SAR ADC Host Readout Controller

This block runs an external 18-bit successive-approximation converter from the host side. It pulses the convert line and waits for the converter's busy signal to drop, using a timeout as a backstop. It then generates a gated shift clock and collects the result MSB first. Each finished word is presented for one cycle with a valid strobe. After reset the block refuses to convert for a start-up hold-off of 20 µs. It also enforces a minimum acquisition gap after every conversion, and it never toggles the shift clock while a conversion is running.

Conversions are requested in one of two ways. A single pulse on `start_i` gives one conversion. Holding `free_run_i` high gives conversions at a fixed sample period. The parameters are the clock frequency, the sample rate and the shift-clock half-period divider. All other cycle counts are derived from fixed nanosecond figures: the hold-off, the convert-high width, the conversion timeout and the acquisition time.

The controller is a five-state machine:
- HOLDOFF is the reset state. When the hold-off count expires it goes to IDLE.
- IDLE goes to CNV_HI on a request, provided the acquisition gap has elapsed. A free-running request also needs the sample period to have elapsed.
- CNV_HI holds the convert line high for its fixed width, then goes to CONVERT.
- CONVERT goes to READ once the synchronised busy has been seen high and then low. It goes back to IDLE if the timeout expires first.
- READ goes to IDLE after the final falling edge of the shift clock.

Top module: `sar_readout_ctrl`

## Requirements
- R1: While reset is asserted, `adc_cnv_o`, `adc_sck_o`, `result_valid_o` and `timeout_err_o` are all low.
- R2: No convert edge occurs within HOLD_CYC cycles after reset is released (5000 cycles at the defaults). A request made during the hold-off is dropped, not remembered. A request held across the end of the hold-off is served within 4 cycles of the hold-off ending.
- R3: Each conversion drives `adc_cnv_o` high for exactly CNV_HI_CYC cycles (5 at the defaults, 20 ns). The line then stays low until the conversion has finished. Requests made during conversion or readout are dropped.
- R4: Readout begins only after busy has been seen high and then low. No rising edge of the shift clock occurs while `adc_busy_i` is high.
- R5: A readout has exactly 18 rising edges of `adc_sck_o`. Each rising edge captures `adc_sdo_i` as it was just before that edge. The first capture is bit 17 of the result, so the word is filled MSB first. The shift clock is low whenever no readout is in progress.
- R6: After the last bit, `result_valid_o` is high for exactly one cycle, and `result_o` then holds the captured 18-bit word.
- R7: If busy has not fallen within TOUT_CYC cycles of entering CONVERT, `timeout_err_o` goes high. In that case no shift clock and no valid strobe occur. The flag stays high until the next convert edge, which clears it.
- R8: At least ACQ_CYC cycles (50 at the defaults, 200 ns) pass between the fall of busy and the next convert edge.
- R9: With `free_run_i` high, convert edges are exactly SAMPLE_CYC cycles apart (250 at the defaults), provided a whole conversion cycle fits inside that period.
- R10: A single `start_i` pulse in IDLE produces exactly one conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request for a single conversion |
| free_run_i | input | 1 | Convert repeatedly at the sample period while high |
| adc_busy_i | input | 1 | Busy signal from the converter; synchronised internally |
| adc_sdo_i | input | 1 | Serial data from the converter |
| adc_cnv_o | output | 1 | Convert strobe to the converter |
| adc_sck_o | output | 1 | Shift clock to the converter; low when idle |
| result_o | output | 18 | Last captured conversion word |
| result_valid_o | output | 1 | One-cycle strobe when a new word is ready |
| timeout_err_o | output | 1 | Set when busy failed to fall in time |

## Verification
If a counter or state register goes wrong, the effect shows at the ports within one conversion cycle, as one of three symptoms:
- The convert pulse is wider or narrower than 5 cycles, or the convert edges drift from the 250-cycle free-running spacing or from the 50-cycle acquisition minimum.
- The number of shift-clock rising edges in a frame differs from 18, or a shift-clock edge falls inside busy.
- A mis-aligned shift register delivers a word with its bits moved from their expected positions. This is visible at the first valid strobe, which the walking-pattern vectors are chosen to expose.

A stuck timeout or a stuck hold-off counter shows up as a missing conversion or an error flag that never changes, well inside 6000 cycles.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [2:0] {
        S_HOLDOFF,
        S_IDLE,
        S_CNV_HI,
        S_CONVERT,
        S_READ
    } sar_state_t;

    // Number of clock cycles covering ns nanoseconds, rounded up.
    function automatic int unsigned ns2cyc(longint unsigned hz, longint unsigned ns);
        return int'((hz * ns + 64'd999_999_999) / 64'd1_000_000_000);
    endfunction

endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/sar_sck_gen.sv
module sar_sck_gen #(
    parameter int unsigned DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic sck_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int unsigned CW = $clog2(DIV + 1);

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap   = (cnt == CW'(DIV - 1));
    assign rise_o = en_i && wrap && !sck_o;
    assign fall_o = en_i && wrap &&  sck_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            sck_o <= 1'b0;
        end else if (!en_i) begin
            cnt   <= '0;
            sck_o <= 1'b0;
        end else if (wrap) begin
            cnt   <= '0;
            sck_o <= ~sck_o;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sar_shift_in.sv
module sar_shift_in #(
    parameter int unsigned W = 18
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr_i,
    input  logic                   shift_i,
    input  logic                   d_i,
    output logic [W-1:0]           q_o,
    output logic [$clog2(W+1)-1:0] n_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_o <= '0;
            n_o <= '0;
        end else if (clr_i) begin
            n_o <= '0;
        end else if (shift_i) begin
            q_o <= {q_o[W-2:0], d_i};
            n_o <= n_o + 1'b1;
        end
    end
endmodule

// File: rtl/sar_readout_ctrl.sv
module sar_readout_ctrl
    import sar_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 250_000_000,
    parameter int unsigned SAMPLE_HZ   = 1_000_000,
    parameter int unsigned SCK_DIV     = 2,
    parameter int unsigned DATA_W      = 18,
    parameter int unsigned HOLDOFF_NS  = 20_000,
    parameter int unsigned CNV_HI_NS   = 20,
    parameter int unsigned CONV_MAX_NS = 412,
    parameter int unsigned ACQ_NS      = 200,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              free_run_i,
    input  logic              adc_busy_i,
    input  logic              adc_sdo_i,
    output logic              adc_cnv_o,
    output logic              adc_sck_o,
    output logic [DATA_W-1:0] result_o,
    output logic              result_valid_o,
    output logic              timeout_err_o
);
    localparam int unsigned HOLD_CYC   = ns2cyc(CLK_HZ, HOLDOFF_NS);
    localparam int unsigned CNV_HI_CYC = ns2cyc(CLK_HZ, CNV_HI_NS);
    localparam int unsigned TOUT_CYC   = ns2cyc(CLK_HZ, CONV_MAX_NS) + SYNC_STAGES + 6;
    localparam int unsigned ACQ_CYC    = ns2cyc(CLK_HZ, ACQ_NS);
    localparam int unsigned SAMPLE_CYC = CLK_HZ / SAMPLE_HZ;
    localparam int unsigned HW = $clog2(HOLD_CYC + 1);
    localparam int unsigned PW = $clog2(TOUT_CYC + CNV_HI_CYC + 1);
    localparam int unsigned AW = $clog2(ACQ_CYC + 1);
    localparam int unsigned SW = $clog2(SAMPLE_CYC + 1);
    localparam int unsigned NW = $clog2(DATA_W + 1);

    sar_state_t        state, state_n;
    logic [HW-1:0]     hold_cnt;
    logic [PW-1:0]     phase_cnt;
    logic [AW-1:0]     acq_cnt;
    logic [SW-1:0]     per_cnt;
    logic              busy_s, busy_seen;
    logic              sck_rise, sck_fall;
    logic [DATA_W-1:0] shq;
    logic [NW-1:0]     nbits;
    logic              acq_ok, per_ok, conv_done, tout_hit, frame_done, launch;

    sar_sync #(.STAGES(SYNC_STAGES)) u_busy_sync (
        .clk(clk), .rst_n(rst_n), .d_i(adc_busy_i), .q_o(busy_s)
    );

    sar_sck_gen #(.DIV(SCK_DIV)) u_sck (
        .clk(clk), .rst_n(rst_n), .en_i(state == S_READ),
        .sck_o(adc_sck_o), .rise_o(sck_rise), .fall_o(sck_fall)
    );

    sar_shift_in #(.W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .clr_i(state != S_READ),
        .shift_i(sck_rise), .d_i(adc_sdo_i), .q_o(shq), .n_o(nbits)
    );

    assign acq_ok     = (acq_cnt >= AW'(ACQ_CYC - 1));
    assign per_ok     = (per_cnt >= SW'(SAMPLE_CYC - 1));
    assign conv_done  = busy_seen && !busy_s;
    assign tout_hit   = (state == S_CONVERT) && !conv_done && (phase_cnt == PW'(TOUT_CYC - 1));
    assign frame_done = sck_fall && (nbits == NW'(DATA_W));
    assign launch     = (state_n == S_CNV_HI) && (state != S_CNV_HI);

    // Next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            S_HOLDOFF: if (hold_cnt == HW'(HOLD_CYC - 1)) state_n = S_IDLE;
            S_IDLE:    if (acq_ok && (start_i || (free_run_i && per_ok))) state_n = S_CNV_HI;
            S_CNV_HI:  if (phase_cnt == PW'(CNV_HI_CYC - 1)) state_n = S_CONVERT;
            S_CONVERT: if (conv_done) state_n = S_READ;
                       else if (tout_hit) state_n = S_IDLE;
            S_READ:    if (frame_done) state_n = S_IDLE;
            default:   state_n = S_HOLDOFF;
        endcase
    end

    // State register and its timers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_HOLDOFF;
            hold_cnt  <= '0;
            phase_cnt <= '0;
            acq_cnt   <= AW'(ACQ_CYC);
            per_cnt   <= SW'(SAMPLE_CYC);
            busy_seen <= 1'b0;
        end else begin
            state <= state_n;
            if (state == S_HOLDOFF) hold_cnt <= hold_cnt + 1'b1;
            phase_cnt <= (state_n != state) ? '0 : phase_cnt + 1'b1;
            if (state == S_CONVERT && state_n != S_CONVERT) acq_cnt <= '0;
            else if (acq_cnt != AW'(ACQ_CYC))               acq_cnt <= acq_cnt + 1'b1;
            if (launch)                            per_cnt <= '0;
            else if (per_cnt != SW'(SAMPLE_CYC))   per_cnt <= per_cnt + 1'b1;
            if (launch)                                busy_seen <= 1'b0;
            else if (state == S_CONVERT && busy_s)     busy_seen <= 1'b1;
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            adc_cnv_o      <= 1'b0;
            result_o       <= '0;
            result_valid_o <= 1'b0;
            timeout_err_o  <= 1'b0;
        end else begin
            adc_cnv_o      <= (state_n == S_CNV_HI);
            result_valid_o <= frame_done;
            if (frame_done) result_o <= shq;
            if (launch)        timeout_err_o <= 1'b0;
            else if (tout_hit) timeout_err_o <= 1'b1;
        end
    end
endmodule

// File: rtl/sar_readout_chk.sv
module sar_readout_chk #(
    parameter int unsigned HOLD_CYC   = 5000,
    parameter int unsigned CNV_HI_CYC = 5
) (
    input logic clk,
    input logic rst_n,
    input logic cnv,
    input logic sck,
    input logic busy,
    input logic valid,
    input logic err
);
    logic [31:0] since_rst;
    logic [31:0] hi_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
            hi_len    <= '0;
        end else begin
            if (since_rst != HOLD_CYC) since_rst <= since_rst + 1;
            hi_len <= cnv ? hi_len + 1 : '0;
        end
    end

    assert_holdoff_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnv) |-> (since_rst >= HOLD_CYC));

    assert_cnv_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cnv) |-> (hi_len == CNV_HI_CYC));

    assert_sck_not_in_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |-> !busy);

    assert_sck_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnv |-> !sck);

    assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    assert_err_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnv) |-> !err);
endmodule

bind sar_readout_ctrl sar_readout_chk #(
    .HOLD_CYC(HOLD_CYC), .CNV_HI_CYC(CNV_HI_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cnv(adc_cnv_o), .sck(adc_sck_o),
    .busy(adc_busy_i), .valid(result_valid_o), .err(timeout_err_o)
);

// File: tb/sar_readout_ctrl_tb.sv
`timescale 1ns/1ps
module sar_readout_ctrl_tb;
    localparam int HOLD   = 5000;  // 20 us at 4 ns
    localparam int CNVHI  = 5;     // 20 ns
    localparam int TOUT   = 111;   // 103 + 2 sync + 6 margin
    localparam int ACQ    = 50;    // 200 ns
    localparam int SAMPLE = 250;   // 1 MHz

    // {conversion cycles[7:0], word[17:0]}
    localparam logic [25:0] VEC [6] = '{
        {8'd20,  18'h3FFFF}, {8'd40, 18'h00000}, {8'd60, 18'h2AAAA},
        {8'd80,  18'h15555}, {8'd100,18'h20001}, {8'd10, 18'h1E0F3}
    };

    logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, free_run_i = 1'b0;
    logic adc_busy_i = 1'b0, adc_sdo_i = 1'b0;
    logic adc_cnv_o, adc_sck_o, result_valid_o, timeout_err_o;
    logic [17:0] result_o;

    sar_readout_ctrl #(.SCK_DIV(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .free_run_i(free_run_i),
        .adc_busy_i(adc_busy_i), .adc_sdo_i(adc_sdo_i), .adc_cnv_o(adc_cnv_o),
        .adc_sck_o(adc_sck_o), .result_o(result_o), .result_valid_o(result_valid_o),
        .timeout_err_o(timeout_err_o)
    );

    always #2 clk = ~clk;

    int checks = 0, errors = 0;
    int cyc = 0, rises = 0, first_rise = -1, last_rise = 0, rise_gap = 0;
    int last_fall = -1, min_gap = 1 << 30, sck_frame = 0, sck_busy = 0, nvalid = 0;
    int bit_idx = 0, cur_conv = 20;
    logic [17:0] cur_word = '0;
    logic stuck = 1'b0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Monitors
    always @(posedge clk) if (!rst_n) cyc = 0; else cyc++;
    always @(posedge adc_cnv_o) begin
        rises++;
        if (first_rise < 0) first_rise = cyc;
        rise_gap = cyc - last_rise;
        last_rise = cyc;
        if (last_fall >= 0 && cyc - last_fall < min_gap) min_gap = cyc - last_fall;
        sck_frame = 0;
    end
    always @(posedge adc_sck_o) begin
        sck_frame++;
        if (adc_busy_i) sck_busy++;
    end
    always @(negedge adc_busy_i) last_fall = cyc;
    always @(negedge clk) if (result_valid_o) nvalid++;

    // Converter model
    initial begin
        forever begin
            @(posedge adc_cnv_o);
            #1 adc_busy_i = 1'b1;
            while (stuck) @(posedge clk);
            repeat (cur_conv) @(posedge clk);
            #1 adc_busy_i = 1'b0;
            bit_idx = 0;
            adc_sdo_i = cur_word[17];
        end
    end
    always @(posedge adc_sck_o) begin
        #1;
        bit_idx++;
        adc_sdo_i = (bit_idx < 18) ? cur_word[17 - bit_idx] : 1'b0;
    end

    // Watchdog
    initial begin
        repeat (150_000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic wait_valid(output bit got);
        got = 1'b0;
        for (int k = 0; k < 2000 && !got; k++) begin
            @(negedge clk);
            if (result_valid_o) got = 1'b1;
        end
    endtask

    task automatic wait_rise(input int target);
        for (int k = 0; k < 2000 && rises < target; k++) @(negedge clk);
    endtask

    initial begin
        bit got;
        int r0, v0;
        // R1: reset values
        repeat (3) @(negedge clk);
        check({adc_cnv_o, adc_sck_o, result_valid_o, timeout_err_o} == 4'b0, "R1",
              {adc_cnv_o, adc_sck_o, result_valid_o, timeout_err_o}, 0);
        rst_n = 1'b1;

        // R2: request during hold-off is dropped
        while (cyc < 100) @(negedge clk);
        pulse_start();
        while (cyc < 4900) @(negedge clk);
        check(rises == 0, "R2 early", rises, 0);
        start_i = 1'b1;
        wait_rise(1);
        start_i = 1'b0;
        check(first_rise >= HOLD && first_rise <= HOLD + 4, "R2 first edge", first_rise, HOLD);
        wait_valid(got);
        check(got && result_o == cur_word, "R2 first result", result_o, cur_word);

        // Vector walk: R3 R4 R5 R6 R10
        for (int i = 0; i < 6; i++) begin
            cur_conv = int'(VEC[i][25:18]);
            cur_word = VEC[i][17:0];
            repeat (60) @(negedge clk);
            r0 = rises;
            sck_busy = 0;
            pulse_start();
            wait_rise(r0 + 1);
            repeat (8) @(negedge clk);
            pulse_start();   // dropped: conversion running
            wait_valid(got);
            check(got && result_o == cur_word, "R5 word", result_o, cur_word);
            check(sck_frame == 18, "R5 edges", sck_frame, 18);
            check(sck_busy == 0, "R4 sck in busy", sck_busy, 0);
            @(negedge clk);
            check(!result_valid_o, "R6 pulse", result_valid_o, 0);
            check(result_o == cur_word, "R6 hold", result_o, cur_word);
            check(!adc_sck_o, "R5 idle", adc_sck_o, 0);
            repeat (150) @(negedge clk);
            check(rises == r0 + 1, "R10 R3 one conversion", rises - r0, 1);
        end

        // R8: back-to-back requests honour acquisition gap
        cur_conv = 30; cur_word = 18'h0F0F0;
        min_gap = 1 << 30;
        r0 = rises;
        start_i = 1'b1;
        wait_rise(r0 + 4);
        start_i = 1'b0;
        check(min_gap >= ACQ && min_gap < ACQ + 8, "R8 gap", min_gap, ACQ);
        repeat (300) @(negedge clk);

        // R9: free-running spacing
        free_run_i = 1'b1;
        r0 = rises;
        wait_rise(r0 + 1);
        for (int j = 0; j < 3; j++) begin
            wait_rise(r0 + 2 + j);
            check(rise_gap == SAMPLE, "R9 period", rise_gap, SAMPLE);
        end
        free_run_i = 1'b0;
        repeat (400) @(negedge clk);

        // R7: busy stuck high -> timeout
        stuck = 1'b1;
        v0 = nvalid; sck_frame = 0;
        pulse_start();
        repeat (TOUT + 20) @(negedge clk);
        check(timeout_err_o == 1'b1, "R7 flag", timeout_err_o, 1);
        check(nvalid == v0 && sck_frame == 0, "R7 no readout", nvalid - v0 + sck_frame, 0);
        stuck = 1'b0;
        cur_conv = 30; cur_word = 18'h3C3C3;
        repeat (200) @(negedge clk);
        check(timeout_err_o == 1'b1, "R7 sticky", timeout_err_o, 1);
        r0 = rises;
        pulse_start();
        wait_rise(r0 + 1);
        @(negedge clk);
        check(timeout_err_o == 1'b0, "R7 clear", timeout_err_o, 0);
        wait_valid(got);
        check(got && result_o == cur_word, "R7 recovery word", result_o, cur_word);

        summary();
    end
endmodule